// File: doc/BRIEF.md
# Four-Register Byte-Wide Processor Core

This block is a small multi-cycle processor. It has four 8-bit general-purpose registers, named A to D, and an 8-bit program counter. It executes 16-bit instructions, each stored as two consecutive bytes in a 256-byte memory that holds both code and data. The memory is reached through one synchronous port: the address and write strobe are presented in one cycle, and the read byte comes back on the next cycle.

The core repeats a fixed loop: fetch two bytes, decode, then execute. The instruction set has add, subtract, load and store. A mode bit selects between register operands and an 8-bit immediate in the second byte. Loads and stores in immediate mode take their address from an optional base register plus the immediate. A base field of A means that no base is used, so the immediate is an absolute address. A halt input holds the core at an instruction boundary.

Top module: `cpu4r_core`

## Requirements
- R1: A low `rst_n`, sampled on a rising clock edge, sets the program counter and all four registers to zero. While reset is low, `mem_we` stays low.
- R2: The first fetch cycle drives `mem_addr` with the PC. The next cycle drives PC+1. The PC then advances by 2, modulo 256. The byte at PC is the high half of the instruction word (word bit 15 down to 8). Word bit 15 is the mode bit (0 = register form, 1 = immediate form). Bits 14:12 are the opcode: add=000, sub=001, load=010, store=011. Register codes are A=00, B=01, C=10, D=11.
- R3: Register-form add/sub writes the register in bits 7:6 with (register in bits 11:10) plus or minus (register in bits 9:8), modulo 256.
- R4: Immediate-form add/sub writes the register in bits 9:8 with (register in bits 11:10) plus or minus the low byte, modulo 256.
- R5: A register-form load reads the byte at the address held in the register in bits 11:10 and writes it into the register in bits 7:6.
- R6: An immediate-form load whose bits 11:10 are 00 reads the byte at the address given by the low byte and writes it into the register in bits 9:8.
- R7: An immediate-form load whose bits 11:10 are nonzero reads from (that register + low byte) modulo 256.
- R8: A register-form store writes the register in bits 11:10 to the address held in the register in bits 7:6.
- R9: An immediate-form store whose bits 9:8 are 00 writes the register in bits 11:10 to the address given by the low byte.
- R10: An immediate-form store whose bits 9:8 are nonzero writes the register in bits 11:10 to (that register + low byte) modulo 256.
- R11: Opcodes 100 to 111, in either mode, change no register and write no memory. They only advance the PC.
- R12: While `halt` is high at an instruction boundary, the core starts no fetch, holds `mem_addr` steady and does not write. On release it resumes with the next instruction.
- R13: Each store raises `mem_we` for exactly one cycle. The write data and address are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| halt | input | 1 | Hold the core at the next instruction boundary |
| mem_addr | output | 8 | Memory address for fetch, load or store |
| mem_wdata | output | 8 | Store data |
| mem_rdata | input | 8 | Read byte, valid one cycle after its address |
| mem_we | output | 1 | Memory write strobe |

## Verification
A halt request can arrive while a store or a load is still in flight. The core must finish that instruction, with its single write strobe, before it freezes. The bench raises `halt` at a fixed point in the middle of the program, where the core may be in any phase. It then checks that the expected write still appears with the right address and data, and that `mem_addr` stays steady with no strobe once the core is parked. A second overlap is a register-relative address that wraps past 255. This is exercised with a base register of 0xF0 and a large offset, and the write or read address is compared against an instruction-level model.

// File: rtl/cpu4r_pkg.sv
// Package: shared types for the four-register core.
// Assumes byte-wide registers and a two-byte instruction word.
package cpu4r_pkg;
    localparam int NREG   = 4;
    localparam int RIDX_W = $clog2(NREG);

    typedef enum logic [2:0] {
        ST_FA,   // present PC
        ST_FB,   // present PC+1, capture high byte
        ST_FC,   // capture low byte, advance PC
        ST_EXE,  // execute / memory access
        ST_LDW   // load data return
    } phase_t;

    typedef enum logic [1:0] {
        K_NONE,
        K_ALU,
        K_LOAD,
        K_STORE
    } kind_t;

    typedef struct packed {
        kind_t             kind;
        logic              sub;
        logic              use_imm;
        logic [RIDX_W-1:0] ra;     // ALU operand A / store data
        logic [RIDX_W-1:0] rb;     // ALU operand B
        logic [RIDX_W-1:0] rd;     // destination register
        logic [RIDX_W-1:0] ar;     // address register
        logic              ar_en;  // address register used
    } ctl_t;
endpackage

// File: rtl/cpu4r_decode.sv
// Module: instruction decoder.
// Turns the two captured bytes into a control bundle. Purely combinational.
// Assumes DW >= 8, with the fields packed from the top of each byte.
module cpu4r_decode
    import cpu4r_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] hi_byte,
    input  logic [DW-1:0] lo_byte,
    output ctl_t          ctl
);
    logic              mode;
    logic [2:0]        opc;
    logic [RIDX_W-1:0] f_a, f_b, f_c;

    assign mode = hi_byte[DW-1];
    assign opc  = hi_byte[DW-2 -: 3];
    assign f_a  = hi_byte[DW-5 -: RIDX_W];
    assign f_b  = hi_byte[DW-7 -: RIDX_W];
    assign f_c  = lo_byte[DW-1 -: RIDX_W];

    // Map opcode and mode onto operand, destination and address selection.
    always_comb begin
        ctl         = '0;
        ctl.kind    = K_NONE;
        ctl.use_imm = mode;
        ctl.ra      = f_a;
        ctl.rb      = f_b;
        ctl.sub     = opc[0];
        unique case (opc)
            3'b000, 3'b001: begin
                ctl.kind = K_ALU;
                ctl.rd   = mode ? f_b : f_c;
            end
            3'b010: begin
                ctl.kind  = K_LOAD;
                ctl.rd    = mode ? f_b : f_c;
                ctl.ar    = f_a;
                ctl.ar_en = mode ? (f_a != '0) : 1'b1;
            end
            3'b011: begin
                ctl.kind  = K_STORE;
                ctl.ar    = mode ? f_b : f_c;
                ctl.ar_en = mode ? (f_b != '0) : 1'b1;
            end
            default: ctl.kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/cpu4r_regfile.sv
// Module: general-purpose register file.
// One write port and three combinational read ports.
// The synchronous active-low reset clears every entry.
module cpu4r_regfile
    import cpu4r_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [RIDX_W-1:0] waddr,
    input  logic [DW-1:0]     wdata,
    input  logic [RIDX_W-1:0] ra_a,
    input  logic [RIDX_W-1:0] ra_b,
    input  logic [RIDX_W-1:0] ra_c,
    output logic [DW-1:0]     rd_a,
    output logic [DW-1:0]     rd_b,
    output logic [DW-1:0]     rd_c
);
    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Hold or load one register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && waddr == RIDX_W'(g))
                regs[g] <= wdata;
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];
    assign rd_c = regs[ra_c];
endmodule

// File: rtl/cpu4r_exec.sv
// Module: arithmetic unit and address generator.
// Computes the add/sub result and the effective memory address.
// Both wrap modulo 2**DW. Purely combinational.
module cpu4r_exec
    import cpu4r_pkg::*;
#(
    parameter int DW = 8
) (
    input  ctl_t          ctl,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [DW-1:0] opar,
    input  logic [DW-1:0] imm,
    output logic [DW-1:0] alu_y,
    output logic [DW-1:0] addr_y
);
    logic [DW-1:0] second;
    logic [DW-1:0] base;
    logic [DW-1:0] offs;

    // Pick the second operand, then add or subtract it.
    always_comb begin
        second = ctl.use_imm ? imm : opb;
        alu_y  = ctl.sub ? (opa - second) : (opa + second);
    end

    // Form the effective address from the optional base and the optional offset.
    always_comb begin
        base   = ctl.ar_en ? opar : '0;
        offs   = ctl.use_imm ? imm : '0;
        addr_y = base + offs;
    end
endmodule

// File: rtl/cpu4r_core.sv
// Module: top of the four-register multi-cycle core.
// A fetch/execute sequencer drives one synchronous memory port.
// Assumes read data returns one cycle after its address.
// Halt is honoured only at an instruction boundary.
module cpu4r_core
    import cpu4r_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halt,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_we
);
    localparam logic [DW-1:0] PC_STEP = DW'(2);

    phase_t        st_q;
    logic [DW-1:0] pc_q;
    logic [DW-1:0] ir_hi_q, ir_lo_q;
    ctl_t          ctl;
    logic [DW-1:0] opa, opb, opar;
    logic [DW-1:0] alu_y, addr_y;
    logic          rf_we;
    logic [DW-1:0] rf_wdata;
    logic          is_mem;

    cpu4r_decode #(.DW(DW)) u_dec (
        .hi_byte (ir_hi_q),
        .lo_byte (ir_lo_q),
        .ctl     (ctl)
    );

    cpu4r_regfile #(.DW(DW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (ctl.rd),
        .wdata (rf_wdata),
        .ra_a  (ctl.ra),
        .ra_b  (ctl.rb),
        .ra_c  (ctl.ar),
        .rd_a  (opa),
        .rd_b  (opb),
        .rd_c  (opar)
    );

    cpu4r_exec #(.DW(DW)) u_ex (
        .ctl    (ctl),
        .opa    (opa),
        .opb    (opb),
        .opar   (opar),
        .imm    (ir_lo_q),
        .alu_y  (alu_y),
        .addr_y (addr_y)
    );

    // Sequence the phases, capture the instruction bytes and step the PC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_FA;
            pc_q    <= '0;
            ir_hi_q <= '0;
            ir_lo_q <= '0;
        end else begin
            unique case (st_q)
                ST_FA:   if (!halt) st_q <= ST_FB;
                ST_FB: begin
                    ir_hi_q <= mem_rdata;
                    st_q    <= ST_FC;
                end
                ST_FC: begin
                    ir_lo_q <= mem_rdata;
                    pc_q    <= pc_q + PC_STEP;
                    st_q    <= ST_EXE;
                end
                ST_EXE:  st_q <= (ctl.kind == K_LOAD) ? ST_LDW : ST_FA;
                ST_LDW:  st_q <= ST_FA;
                default: st_q <= ST_FA;
            endcase
        end
    end

    assign is_mem = (ctl.kind == K_LOAD) || (ctl.kind == K_STORE);

    // Drive the memory port from the current phase.
    always_comb begin
        mem_addr  = pc_q;
        mem_we    = 1'b0;
        mem_wdata = opa;
        if (st_q == ST_FB)
            mem_addr = pc_q + DW'(1);
        else if (st_q == ST_EXE && is_mem) begin
            mem_addr = addr_y;
            mem_we   = (ctl.kind == K_STORE);
        end
    end

    // Select the register write-back source.
    always_comb begin
        rf_we    = (st_q == ST_EXE && ctl.kind == K_ALU) || (st_q == ST_LDW);
        rf_wdata = (st_q == ST_LDW) ? mem_rdata : alu_y;
    end
endmodule

// File: rtl/cpu4r_chk.sv
// Module: protocol checker for cpu4r_core, attached by bind.
// Observes the memory port, the phase and the PC.
module cpu4r_chk
    import cpu4r_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          halt,
    input logic          mem_we,
    input logic [DW-1:0] mem_addr,
    input phase_t        st,
    input logic [DW-1:0] pc
);
    // R13
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R12
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FA && halt) |=> (st == ST_FA && $stable(pc)));

    // R12
    boundary_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FA) |-> !mem_we);

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FC) |=> (pc == $past(pc) + DW'(2)));

    // R2
    fetch_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FA && !halt) |=> (mem_addr == $past(mem_addr) + DW'(1)));
endmodule

bind cpu4r_core cpu4r_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt     (halt),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .st       (st_q),
    .pc       (pc_q)
);

// File: tb/sim_cpu4r_core.sv
`timescale 1ns/1ps
module sim_cpu4r_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt = 1'b0;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic       mem_we;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    bit halt_done = 1'b0;

    logic [7:0] img [256];
    logic [7:0] ram [256];
    string      tags [256];
    int         q_addr [$];
    int         q_data [$];
    string      q_tag [$];
    int         n_instr = 0;
    int         asm_pc = 0;
    logic       prev_we = 1'b0;

    localparam logic [2:0] OP_ADD = 3'b000, OP_SUB = 3'b001, OP_LD = 3'b010, OP_ST = 3'b011;
    localparam logic [1:0] RA = 2'd0, RB = 2'd1, RC = 2'd2, RD = 2'd3;

    cpu4r_core u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt      (halt),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rdata <= ram[mem_addr];
        if (mem_we) ram[mem_addr] <= mem_wdata;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rr(logic [2:0] op, logic [1:0] s1, logic [1:0] s2, logic [1:0] d);
        return {1'b0, op, s1, s2, d, 6'b0};
    endfunction

    function automatic logic [15:0] im(logic [2:0] op, logic [1:0] s, logic [1:0] d, logic [7:0] v);
        return {1'b1, op, s, d, v};
    endfunction

    task automatic put(input logic [15:0] w, input string t);
        img[asm_pc]     = w[15:8];
        img[asm_pc + 1] = w[7:0];
        tags[asm_pc]    = t;
        asm_pc += 2;
        n_instr++;
    endtask

    // Instruction-level reference: runs the program and queues the expected writes.
    task automatic build_expect();
        int r [4];
        logic [7:0] mm [256];
        int pc = 0;
        for (int i = 0; i < 4; i++) r[i] = 0;
        for (int i = 0; i < 256; i++) mm[i] = img[i];
        for (int k = 0; k < n_instr; k++) begin
            logic [15:0] w;
            int md, op, fa, fb, fc, iv, ad, sec;
            w  = {mm[pc], mm[(pc + 1) % 256]};
            md = int'(w[15]); op = int'(w[14:12]);
            fa = int'(w[11:10]); fb = int'(w[9:8]); fc = int'(w[7:6]); iv = int'(w[7:0]);
            if (op == 0 || op == 1) begin
                sec = md ? iv : r[fb];
                if (md) r[fb] = (op == 0 ? r[fa] + sec : r[fa] - sec) & 255;
                else    r[fc] = (op == 0 ? r[fa] + sec : r[fa] - sec) & 255;
            end else if (op == 2) begin
                if (md) begin
                    ad = ((fa == 0 ? 0 : r[fa]) + iv) % 256;
                    r[fb] = int'(mm[ad]);
                end else
                    r[fc] = int'(mm[r[fa]]);
            end else if (op == 3) begin
                if (md) ad = ((fb == 0 ? 0 : r[fb]) + iv) % 256;
                else    ad = r[fc];
                mm[ad] = 8'(r[fa]);
                q_addr.push_back(ad);
                q_data.push_back(r[fa]);
                q_tag.push_back(tags[pc]);
            end
            pc = (pc + 2) % 256;
        end
    endtask

    // Compare every write strobe against the reference, away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                check(!prev_we, "R13 strobe width", 1, 0);
                if (q_addr.size() == 0)
                    check(1'b0, "R13 unexpected write", int'(mem_addr), -1);
                else begin
                    check(int'(mem_addr) == q_addr[0], {q_tag[0], " address"}, int'(mem_addr), q_addr[0]);
                    check(int'(mem_wdata) == q_data[0], {q_tag[0], " data"}, int'(mem_wdata), q_data[0]);
                    void'(q_addr.pop_front());
                    void'(q_data.pop_front());
                    void'(q_tag.pop_front());
                end
            end
            prev_we = mem_we;
        end
    end

    // Halt in mid-program: the core must park with a steady address and no writes.
    initial begin
        logic [7:0] held;
        bit steady;
        wait (rst_n);
        repeat (30) @(negedge clk);
        halt = 1'b1;
        repeat (6) @(negedge clk);
        held = mem_addr;
        steady = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (mem_addr != held || mem_we) steady = 1'b0;
        end
        check(steady, "R12 halted port", int'(mem_addr), int'(held));
        halt = 1'b0;
        halt_done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin img[i] = 8'h00; tags[i] = ""; end
        img[8'hA0] = 8'h37; img[8'hA1] = 8'hF0; img[8'hA2] = 8'h5A;
        img[8'hA3] = 8'hA2; img[8'hA4] = 8'h6B;
        put(im(OP_ST, RD, RA, 8'h90), "R1 R9");
        put(im(OP_LD, RA, RA, 8'hA0), "");
        put(im(OP_LD, RA, RB, 8'hA1), "");
        put(im(OP_ST, RA, RA, 8'h99), "R6 R9");
        put(rr(OP_ADD, RA, RB, RC), "");
        put(im(OP_ST, RC, RA, 8'h91), "R3 add wrap");
        put(rr(OP_SUB, RA, RB, RD), "");
        put(im(OP_ST, RD, RA, 8'h92), "R3 sub wrap");
        put(im(OP_ADD, RB, RD, 8'h20), "");
        put(im(OP_ST, RD, RA, 8'h93), "R4 add");
        put(im(OP_SUB, RD, RC, 8'd25), "");
        put(im(OP_ST, RC, RA, 8'h94), "R4 sub");
        put(rr(3'b100, RA, RB, RC), "");
        put(im(3'b111, RA, RC, 8'h55), "");
        put(rr(3'b110, RC, RC, RC), "");
        put(im(OP_ST, RC, RA, 8'h95), "R11 no-op");
        put(im(OP_LD, RA, RC, 8'hA3), "");
        put(rr(OP_LD, RC, RA, RD), "");
        put(im(OP_ST, RD, RA, 8'h96), "R5");
        put(im(OP_LD, RC, RA, 8'h02), "");
        put(im(OP_LD, RB, RD, 8'hB3), "");
        put(im(OP_ST, RA, RA, 8'h97), "R7 relative");
        put(im(OP_ST, RD, RA, 8'h98), "R7 wrap");
        put(rr(OP_ST, RB, RA, RC), "R8");
        put(im(OP_ST, RA, RC, 8'h10), "R10 relative");
        put(im(OP_ST, RD, RB, 8'hA0), "R10 wrap");
        for (int i = 0; i < 256; i++) ram[i] = img[i];
        build_expect();

        repeat (3) @(negedge clk);
        check(mem_we == 1'b0, "R1 no write in reset", int'(mem_we), 0);
        rst_n = 1'b1;
        check(mem_addr == 8'h00, "R1 PC cleared", int'(mem_addr), 0);
        @(negedge clk);
        check(mem_addr == 8'h01, "R2 second fetch byte", int'(mem_addr), 1);

        while ((q_addr.size() != 0 || !halt_done) && cyc < 20000) @(negedge clk);
        if (q_addr.size() != 0) check(1'b0, "watchdog", q_addr.size(), 0);
        repeat (40) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule